// File: doc/BRIEF.md
# Multi-lane DLL enable sequencer

This block brings a set of delay-locked loops from reset into service. The set is one master DLL and up to four byte-lane slave DLLs. Each DLL gets three control outputs: a phase setting, a disable control and an active-low reset control. The block drives each DLL through the same three steps: load the phase while disabled and in reset, clear the disable while reset is still held, then release reset. Every step lasts a fixed number of microsecond ticks before the next step begins.

A start pulse launches a run. A mode input sampled with start picks one of two runs. The master run touches only the master DLL. The lane run touches only the lane DLLs, and all active lanes move through each step in the same cycle. The bus-width flag sampled with start decides how many lanes are active. Lane phases come from adjacent 4-bit nibbles of a shared configuration word. The master phase comes from a 6-bit field of the same word. A one-cycle done pulse marks the end of each run. The analog DLLs themselves sit outside this block.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, every DLL has disable = 1, reset control = 0 and phase = 0, and done = 0.
- R2: A start with mode = 0 (master run) loads the master phase from configuration bits 21:16, with master disable = 1 and reset control = 0, in the cycle after start is sampled.
- R3: In a lane run, lane k (k = 1..4) loads its phase from configuration bits 4k-1:4k-4. Lane k appears on lane_phase bits 4k-1:4k-4, and its controls on bit k-1 of lane_disable and lane_rst_n.
- R4: wide_bus = 1 makes all four lanes active, and wide_bus = 0 makes only lanes 1 and 2 active. In a lane run, inactive lanes get disable = 1 and reset control = 0 from the first step onward, even if an earlier run enabled them, and they keep their old phase.
- R5: The first step lasts exactly 2 us_tick pulses. Its values stay in place after the first tick, and the second step's values appear in the cycle after the second tick is sampled.
- R6: The second step drives disable = 0 and reset control = 0 on the DLLs being run, and lasts exactly 22 ticks.
- R7: The third step drives reset control = 1 with disable = 0, and lasts exactly 22 ticks. done is then high for exactly one cycle, in the cycle after the last tick is sampled. The final values stay in place after the run.
- R8: All active lanes change their controls in the same cycle at each step.
- R9: A start that arrives while a run is in progress is ignored: the phase, the mode and the step timing of the current run do not change.
- R10: A master run leaves every lane output unchanged, and a lane run leaves every master output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| run_lanes | input | 1 | Run select sampled with start: 0 master, 1 lanes |
| phase_cfg | input | 32 | Phase configuration word |
| wide_bus | input | 1 | Bus width flag sampled with start: 1 selects four lanes |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| mst_phase | output | 6 | Master DLL phase |
| mst_disable | output | 1 | Master DLL disable |
| mst_rst_n | output | 1 | Master DLL reset, active low |
| lane_phase | output | 16 | Lane DLL phases, lane 1 in bits 3:0 |
| lane_disable | output | 4 | Lane DLL disables, lane 1 in bit 0 |
| lane_rst_n | output | 4 | Lane DLL resets, active low, lane 1 in bit 0 |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
If the step state is wrong, the DLL controls at the ports show it at the very next tick boundary. A step that ends one tick early or late moves the disable or reset edge by one microsecond, so the bench checks each step both at the tick before its boundary and at the boundary. A wrong width or mode latch shows up in the same cycle the run starts: a parked lane is left enabled, or the DLLs of the other run change. A stray start during a run would reload a phase right away, or stretch the run by a step and so delay done.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_HOLD = 2'd2,
    STEP_RUN  = 2'd3
  } step_t;
endpackage

// File: rtl/dll_step_timer.sv
module dll_step_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (active && tick) cnt <= cnt + 1'b1;
  end

  assign expire = active && tick && (cnt == limit - 1'b1);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (active && !$past(clear) && $past(active)) |-> (cnt < limit)); // R5
endmodule

// File: rtl/dll_lane_mask.sv
module dll_lane_mask #(
  parameter int NUM_LANES    = 4,
  parameter int NARROW_LANES = 2
) (
  input  logic                 wide,
  output logic [NUM_LANES-1:0] mask
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_mask
    if (i < NARROW_LANES) begin : g_always
      assign mask[i] = 1'b1;
    end else begin : g_wide
      assign mask[i] = wide;
    end
  end
endmodule

// File: rtl/dll_slot.sv
module dll_slot
  import dll_seq_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            apply,
  input  step_t           step,
  input  logic            active,
  input  logic [PH_W-1:0] phase_in,
  output logic [PH_W-1:0] phase_q,
  output logic            dis_q,
  output logic            rst_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      dis_q   <= 1'b1;
      rst_n_q <= 1'b0;
    end else if (apply) begin
      if (!active) begin
        dis_q   <= 1'b1;
        rst_n_q <= 1'b0;
      end else begin
        case (step)
          STEP_LOAD: begin
            phase_q <= phase_in;
            dis_q   <= 1'b1;
            rst_n_q <= 1'b0;
          end
          STEP_HOLD: begin
            dis_q   <= 1'b0;
            rst_n_q <= 1'b0;
          end
          STEP_RUN: begin
            dis_q   <= 1'b0;
            rst_n_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_RELEASE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> !dis_q); // R7
  AST_ENABLE_UNDER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(dis_q) |-> !rst_n_q); // R6
endmodule

// File: rtl/dll_bringup_ctrl.sv
module dll_bringup_ctrl
  import dll_seq_pkg::*;
#(
  parameter int T_LOAD_US = 2,
  parameter int T_HOLD_US = 22,
  parameter int T_RUN_US  = 22,
  parameter int CNT_W     = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  run_lanes,
  input  logic  wide_bus,
  input  logic  us_tick,
  output logic  apply,
  output step_t step_cmd,
  output logic  lanes_now,
  output logic  wide_now,
  output logic  busy,
  output logic  lanes_q,
  output logic  wide_q,
  output logic  done
);
  step_t            state;
  logic             expire;
  logic [CNT_W-1:0] limit;

  always_comb begin
    case (state)
      STEP_LOAD: limit = CNT_W'(T_LOAD_US);
      STEP_HOLD: limit = CNT_W'(T_HOLD_US);
      default:   limit = CNT_W'(T_RUN_US);
    endcase
  end

  dll_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (apply),
    .active (busy),
    .tick   (us_tick),
    .limit  (limit),
    .expire (expire)
  );

  assign busy      = (state != STEP_IDLE);
  assign lanes_now = busy ? lanes_q : run_lanes;
  assign wide_now  = busy ? wide_q  : wide_bus;

  always_comb begin
    apply    = 1'b0;
    step_cmd = STEP_IDLE;
    case (state)
      STEP_IDLE: if (start)  begin apply = 1'b1; step_cmd = STEP_LOAD; end
      STEP_LOAD: if (expire) begin apply = 1'b1; step_cmd = STEP_HOLD; end
      STEP_HOLD: if (expire) begin apply = 1'b1; step_cmd = STEP_RUN;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= STEP_IDLE;
      lanes_q <= 1'b0;
      wide_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        STEP_IDLE: if (start) begin
          state   <= STEP_LOAD;
          lanes_q <= run_lanes;
          wide_q  <= wide_bus;
        end
        STEP_LOAD: if (expire) state <= STEP_HOLD;
        STEP_HOLD: if (expire) state <= STEP_RUN;
        default: if (expire) begin
          state <= STEP_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !expire) |=> (state == $past(state))); // R9
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(lanes_q) && $stable(wide_q))); // R9
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int NARROW_LANES = 2,
  parameter int CFG_W        = 32,
  parameter int MST_PH_W     = 6,
  parameter int MST_PH_LSB   = 16,
  parameter int LANE_PH_W    = 4,
  parameter int T_LOAD_US    = 2,
  parameter int T_HOLD_US    = 22,
  parameter int T_RUN_US     = 22
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic                            run_lanes,
  input  logic [CFG_W-1:0]                phase_cfg,
  input  logic                            wide_bus,
  input  logic                            us_tick,
  output logic [MST_PH_W-1:0]             mst_phase,
  output logic                            mst_disable,
  output logic                            mst_rst_n,
  output logic [NUM_LANES*LANE_PH_W-1:0]  lane_phase,
  output logic [NUM_LANES-1:0]            lane_disable,
  output logic [NUM_LANES-1:0]            lane_rst_n,
  output logic                            done
);
  localparam int T_MAX01 = (T_LOAD_US > T_HOLD_US) ? T_LOAD_US : T_HOLD_US;
  localparam int T_MAX   = (T_MAX01 > T_RUN_US) ? T_MAX01 : T_RUN_US;
  localparam int CNT_W   = $clog2(T_MAX + 1);

  logic                 apply, lanes_now, wide_now, busy, lanes_q, wide_q;
  step_t                step_cmd;
  logic [NUM_LANES-1:0] lane_act;
  logic                 unused_cfg;

  assign unused_cfg = ^phase_cfg;

  dll_bringup_ctrl #(
    .T_LOAD_US (T_LOAD_US),
    .T_HOLD_US (T_HOLD_US),
    .T_RUN_US  (T_RUN_US),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .run_lanes (run_lanes),
    .wide_bus  (wide_bus),
    .us_tick   (us_tick),
    .apply     (apply),
    .step_cmd  (step_cmd),
    .lanes_now (lanes_now),
    .wide_now  (wide_now),
    .busy      (busy),
    .lanes_q   (lanes_q),
    .wide_q    (wide_q),
    .done      (done)
  );

  dll_lane_mask #(
    .NUM_LANES    (NUM_LANES),
    .NARROW_LANES (NARROW_LANES)
  ) u_mask (
    .wide (wide_now),
    .mask (lane_act)
  );

  dll_slot #(.PH_W(MST_PH_W)) u_master (
    .clk      (clk),
    .rst      (rst),
    .apply    (apply && !lanes_now),
    .step     (step_cmd),
    .active   (1'b1),
    .phase_in (phase_cfg[MST_PH_LSB +: MST_PH_W]),
    .phase_q  (mst_phase),
    .dis_q    (mst_disable),
    .rst_n_q  (mst_rst_n)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    dll_slot #(.PH_W(LANE_PH_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .apply    (apply && lanes_now),
      .step     (step_cmd),
      .active   (lane_act[i]),
      .phase_in (phase_cfg[i*LANE_PH_W +: LANE_PH_W]),
      .phase_q  (lane_phase[i*LANE_PH_W +: LANE_PH_W]),
      .dis_q    (lane_disable[i]),
      .rst_n_q  (lane_rst_n[i])
    );

    if (i >= NARROW_LANES) begin : g_park_chk
      AST_NARROW_PARKED: assert property (@(posedge clk) disable iff (rst)
        (busy && lanes_q && !wide_q) |-> (lane_disable[i] && !lane_rst_n[i])); // R4
    end
  end

  AST_MASTER_QUIET_IN_LANE_RUN: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && lanes_q) |-> ($stable(mst_disable) && $stable(mst_rst_n) && $stable(mst_phase))); // R10
endmodule

// File: tb/dll_bringup_seq_test.sv
module dll_bringup_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        run_lanes = 1'b0;
  logic [31:0] phase_cfg = '0;
  logic        wide_bus = 1'b0;
  logic        us_tick = 1'b0;
  logic [5:0]  mst_phase;
  logic        mst_disable, mst_rst_n;
  logic [15:0] lane_phase;
  logic [3:0]  lane_disable, lane_rst_n;
  logic        done;

  int checks = 0;
  int errors = 0;

  logic [5:0]  e_mph  = '0;
  logic        e_mdis = 1'b1;
  logic        e_mrn  = 1'b0;
  logic [15:0] e_lph  = '0;
  logic [3:0]  e_ldis = 4'hF;
  logic [3:0]  e_lrn  = 4'h0;

  always #4 clk = ~clk;

  dll_bringup_seq uut (
    .clk (clk), .rst (rst), .start (start), .run_lanes (run_lanes),
    .phase_cfg (phase_cfg), .wide_bus (wide_bus), .us_tick (us_tick),
    .mst_phase (mst_phase), .mst_disable (mst_disable), .mst_rst_n (mst_rst_n),
    .lane_phase (lane_phase), .lane_disable (lane_disable), .lane_rst_n (lane_rst_n),
    .done (done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "mst_phase",    32'(mst_phase),    32'(e_mph));
    chk(req, "mst_disable",  32'(mst_disable),  32'(e_mdis));
    chk(req, "mst_rst_n",    32'(mst_rst_n),    32'(e_mrn));
    chk(req, "lane_phase",   32'(lane_phase),   32'(e_lph));
    chk(req, "lane_disable", 32'(lane_disable), 32'(e_ldis));
    chk(req, "lane_rst_n",   32'(lane_rst_n),   32'(e_lrn));
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
    end
  endtask

  task automatic do_start(input logic lanes, input logic wide, input logic [31:0] word);
    @(negedge clk);
    start = 1'b1; run_lanes = lanes; wide_bus = wide; phase_cfg = word;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input string req);
    tick_n(21);
    chk(req, "done before last tick", 32'(done), 32'd0);
    tick_n(1);
    chk(req, "done after last tick", 32'(done), 32'd1);
    @(negedge clk);
    chk(req, "done one cycle", 32'(done), 32'd0);
    check_all(req);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");
    chk("R1", "done", 32'(done), 32'd0);
  endtask

  task automatic test_master(input logic [31:0] word, input bit inject);
    do_start(1'b0, 1'b1, word);
    e_mph = word[21:16]; e_mdis = 1'b1; e_mrn = 1'b0;
    check_all("R2");
    tick_n(1);
    check_all("R5");
    tick_n(1);
    e_mdis = 1'b0;
    check_all("R6");
    if (inject) begin
      tick_n(10);
      do_start(1'b1, 1'b1, ~word);
      check_all("R9");
      tick_n(11);
    end else begin
      tick_n(21);
    end
    check_all("R6");
    tick_n(1);
    e_mrn = 1'b1;
    check_all("R7");
    finish_run("R10");
  endtask

  task automatic test_lanes(input logic [31:0] word, input logic wide);
    logic [3:0] act;
    act = wide ? 4'hF : 4'h3;
    do_start(1'b1, wide, word);
    for (int i = 0; i < 4; i++)
      if (act[i]) e_lph[i*4 +: 4] = word[i*4 +: 4];
    e_ldis = 4'hF; e_lrn = 4'h0;
    check_all("R3");
    tick_n(1);
    check_all("R5");
    tick_n(1);
    e_ldis = ~act;
    check_all("R8");
    tick_n(21);
    check_all("R6");
    tick_n(1);
    e_lrn = act;
    check_all("R4");
    finish_run("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_master(32'hA53F_C7E1, 1'b0);
    test_lanes(32'h0012_9B6D, 1'b1);
    test_lanes(32'hFF00_4E25, 1'b0);
    test_master(32'h0015_0000, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule